// File: doc/BRIEF.md
# Lock-Gated Receive FIFO Reset Controller

This block produces the two resets around a clock-crossing FIFO on a serial receive path. The write side of that FIFO, and the PCS logic in front of it, run on the clock recovered by the transceiver. That clock may be missing or unstable until the transceiver locks. The read side runs on the system clock. A dual-clock FIFO that is reset while its write clock is stopped can come up corrupted and stall for good. The controller therefore holds the receive domain in reset until the transceiver reports ready. It then keeps that reset asserted for a set number of receive-clock edges that were actually seen before it lets go.

The receive-domain reset is the AND of two terms: the global reset brought into the receive clock by an unreset synchronizer chain, and the ready flag. It also waits for a hold counter that counts only live receive-clock edges. The system-domain reset is the global reset passed straight through. The controller also watches the FIFO's empty and almost-full flags on the receive clock. Both flags high together show a FIFO that was reset wrongly. That condition latches a sticky error, which is carried into the system clock domain.

Top module: `rxfifo_rst_ctrl`

## Requirements
- R1: `rst_n_sys_o` equals `rst_n_glob_i` at all times, with no clock involved.
- R2: `rst_n_rx_o` is low immediately, without a clock edge, whenever `rst_n_glob_i` is low or `xcvr_rdy_i` is low.
- R3: With `xcvr_rdy_i` high, `rst_n_rx_o` rises after exactly SYNC_STAGES + HOLD_CYC receive-clock rising edges following the release of `rst_n_glob_i` (10 edges with the defaults 2 and 8).
- R4: With the global reset released and synchronized, `rst_n_rx_o` rises after exactly HOLD_CYC receive-clock rising edges at which `xcvr_rdy_i` was sampled high, counted from the rise of `xcvr_rdy_i`.
- R5: If `xcvr_rdy_i` is sampled low at any receive-clock edge, the hold count restarts from zero, so a full HOLD_CYC further edges with ready high are needed even after a one-cycle dip.
- R6: A HOLD_CYC below 3 is treated as 3. With HOLD_CYC = 1, release follows 3 edges after ready, or 5 edges after the global release.
- R7: The stall error latches only when `fifo_empty_i` and `fifo_afull_i` are both high at one receive-clock edge while `rst_n_rx_o` is high. Either flag alone, or both together while the receive domain is in reset, leave it clear.
- R8: `stall_err_o` goes high on the second system-clock rising edge after the receive-domain latch sets. It then stays high, and only a low `rst_n_glob_i` clears it, at once.
- R9: While the receive clock is stopped, the hold count does not advance, and `rst_n_rx_o` stays low however long the stop lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n_glob_i | input | 1 | Global reset, active low, asynchronous |
| xcvr_rdy_i | input | 1 | Transceiver locked and aligned |
| rx_clk_i | input | 1 | Recovered receive clock, may be absent |
| sys_clk_i | input | 1 | System clock |
| fifo_empty_i | input | 1 | FIFO empty flag, sampled on rx_clk_i |
| fifo_afull_i | input | 1 | FIFO almost-full flag, sampled on rx_clk_i |
| rst_n_rx_o | output | 1 | Receive-domain reset, active low (PCS and FIFO write side) |
| rst_n_sys_o | output | 1 | System-domain reset, active low (FIFO read side) |
| stall_err_o | output | 1 | Sticky FIFO stall error, system clock domain |

## Verification
A hold counter that is off by one shows up as a receive reset released one edge early or late. The bench therefore samples the release on the exact edge, both after a global release and after each return of the ready flag. A counter that failed to restart would show on the first full hold after a one-edge dip in ready. A counter that ran with the clock stopped would show as an early release within a few edges of the restart. A stall latch that set wrongly, or a synchronizer with the wrong depth, shows on `stall_err_o` within two or three system-clock edges.

// File: rtl/rstc_pkg.sv
`timescale 1ns/100ps
package rstc_pkg;

  // Smallest hold that still gives a dual-clock FIFO a valid reset.
  localparam int unsigned RSTC_MIN_HOLD = 3;

  // Hold length actually used: requests below the floor are raised.
  function automatic int unsigned rstc_hold_eff(input int unsigned req);
    return (req < RSTC_MIN_HOLD) ? RSTC_MIN_HOLD : req;
  endfunction

  // Counter width able to hold the value "hold".
  function automatic int unsigned rstc_cnt_w(input int unsigned hold);
    return (hold < 2) ? 1 : $clog2(hold + 1);
  endfunction

  // Synchronizer length, never shorter than two flops.
  function automatic int unsigned rstc_sync_len(input int unsigned req);
    return (req < 2) ? 2 : req;
  endfunction

endpackage

// File: rtl/rstc_sync_chain.sv
`timescale 1ns/100ps
module rstc_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter bit          HAS_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  import rstc_pkg::*;

  localparam int unsigned LEN = rstc_sync_len(STAGES);

  logic [LEN-1:0] ff_q;

  generate
    if (HAS_RST) begin : g_arst
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) ff_q <= '0;
        else          ff_q <= {ff_q[LEN-2:0], d_i};
      end
    end else begin : g_free
      // Chain without reset: it must work while its own clock is absent.
      logic unused_rst_n;
      assign unused_rst_n = rst_n_i;
      always_ff @(posedge clk_i) begin
        ff_q <= {ff_q[LEN-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[LEN-1];

endmodule

// File: rtl/rstc_hold_gate.sv
`timescale 1ns/100ps
module rstc_hold_gate #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic glob_sync_i,
  input  logic rdy_i,
  output logic rst_n_o
);
  import rstc_pkg::*;

  localparam int unsigned HOLD_EFF = rstc_hold_eff(HOLD_CYC);
  localparam int unsigned CW       = rstc_cnt_w(HOLD_EFF);

  logic          gate_n;     // both release terms present
  logic          hold_done;  // enough live edges counted
  logic [CW-1:0] cnt_q;

  assign gate_n    = glob_sync_i & rdy_i;
  assign hold_done = (cnt_q == CW'(HOLD_EFF));

  // Counts only real clock edges, so a missing clock never counts.
  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)       cnt_q <= '0;
    else if (!gate_n)    cnt_q <= '0;
    else if (!hold_done) cnt_q <= cnt_q + 1'b1;
  end

  assign rst_n_o = hold_done & gate_n;

  AST_HOLD_MIN: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(rst_n_o) |-> ($past(gate_n, 1) && $past(gate_n, 2) && $past(gate_n, 3))); // R6

  AST_RDY_DROP_RESTART: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    !rdy_i |=> !rst_n_o); // R5

endmodule

// File: rtl/rstc_stall_flag.sv
`timescale 1ns/100ps
module rstc_stall_flag (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic arm_i,
  input  logic empty_i,
  input  logic afull_i,
  output logic err_o
);

  logic bad_combo;
  logic err_q;

  assign bad_combo = arm_i & empty_i & afull_i;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)      err_q <= 1'b0;
    else if (bad_combo) err_q <= 1'b1;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    err_q |=> err_q); // R8

  AST_ERR_ARMED: assert property (@(posedge clk_i) disable iff (!arst_n_i)
    $rose(err_q) |-> $past(arm_i)); // R7

endmodule

// File: rtl/rxfifo_rst_ctrl.sv
`timescale 1ns/100ps
module rxfifo_rst_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 8
) (
  input  logic rst_n_glob_i,
  input  logic xcvr_rdy_i,
  input  logic rx_clk_i,
  input  logic sys_clk_i,
  input  logic fifo_empty_i,
  input  logic fifo_afull_i,
  output logic rst_n_rx_o,
  output logic rst_n_sys_o,
  output logic stall_err_o
);

  logic glob_rx_sync;  // global reset seen in the receive domain
  logic rst_n_rx;      // gated receive reset
  logic err_rx;        // sticky stall flag, receive domain
  logic err_sys;       // same flag after crossing

  rstc_sync_chain #(
    .STAGES  (SYNC_STAGES),
    .HAS_RST (1'b0)
  ) i_glob_sync (
    .clk_i   (rx_clk_i),
    .rst_n_i (1'b1),
    .d_i     (rst_n_glob_i),
    .q_o     (glob_rx_sync)
  );

  rstc_hold_gate #(
    .HOLD_CYC (HOLD_CYC)
  ) i_hold (
    .clk_i       (rx_clk_i),
    .arst_n_i    (rst_n_glob_i),
    .glob_sync_i (glob_rx_sync),
    .rdy_i       (xcvr_rdy_i),
    .rst_n_o     (rst_n_rx)
  );

  rstc_stall_flag i_stall (
    .clk_i    (rx_clk_i),
    .arst_n_i (rst_n_glob_i),
    .arm_i    (rst_n_rx),
    .empty_i  (fifo_empty_i),
    .afull_i  (fifo_afull_i),
    .err_o    (err_rx)
  );

  rstc_sync_chain #(
    .STAGES  (2),
    .HAS_RST (1'b1)
  ) i_err_sync (
    .clk_i   (sys_clk_i),
    .rst_n_i (rst_n_glob_i),
    .d_i     (err_rx),
    .q_o     (err_sys)
  );

  assign rst_n_rx_o  = rst_n_rx;
  assign rst_n_sys_o = rst_n_glob_i;
  assign stall_err_o = err_sys;

  AST_ERR_HAS_SOURCE: assert property (@(posedge sys_clk_i) disable iff (!rst_n_glob_i)
    err_sys |-> err_rx); // R8

endmodule

// File: tb/test_rxfifo_rst_ctrl.sv
`timescale 1ns/100ps
module test_rxfifo_rst_ctrl;

  logic rx_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic rx_en = 1'b1;
  logic glob_n = 1'b0;
  logic rdy = 1'b0;
  logic empty = 1'b0;
  logic afull = 1'b0;
  logic rx_n, sys_n, err;
  logic rx_n_h1, sys_n_h1, err_h1;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  // {edges after ready rise, expected main release, expected floor-3 release}
  localparam int unsigned VEC [6][3] = '{
    '{1, 0, 0}, '{2, 0, 0}, '{3, 0, 1},
    '{7, 0, 1}, '{8, 1, 1}, '{11, 1, 1}
  };

  always #2 sys_clk = ~sys_clk;  // 250 MHz
  always begin
    #3;
    if (rx_en) rx_clk = ~rx_clk;
    else       rx_clk = 1'b0;
  end

  rxfifo_rst_ctrl i_rxfifo_rst_ctrl (
    .rst_n_glob_i (glob_n), .xcvr_rdy_i (rdy), .rx_clk_i (rx_clk), .sys_clk_i (sys_clk),
    .fifo_empty_i (empty), .fifo_afull_i (afull),
    .rst_n_rx_o (rx_n), .rst_n_sys_o (sys_n), .stall_err_o (err)
  );

  rxfifo_rst_ctrl #(.HOLD_CYC(1)) i_rxfifo_rst_ctrl_h1 (
    .rst_n_glob_i (glob_n), .xcvr_rdy_i (rdy), .rx_clk_i (rx_clk), .sys_clk_i (sys_clk),
    .fifo_empty_i (1'b0), .fifo_afull_i (1'b0),
    .rst_n_rx_o (rx_n_h1), .rst_n_sys_o (sys_n_h1), .stall_err_o (err_h1)
  );

  task automatic rx_edges(input int n);
    repeat (n) @(posedge rx_clk);
    #0.7;
  endtask

  task automatic sys_edges(input int n);
    repeat (n) @(posedge sys_clk);
    #0.3;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rx_edges(4);
    chk("R2 reset state rx", rx_n, 1'b0);
    chk("R1 reset state sys", sys_n, 1'b0);
    chk("R8 reset state err", err, 1'b0);

    // R7: both flags while the receive domain is in reset
    empty = 1'b1; afull = 1'b1;
    rx_edges(2);
    empty = 1'b0; afull = 1'b0;

    // R3 / R6: release from global reset with ready high
    rdy = 1'b1; glob_n = 1'b1;
    #0.5;
    chk("R1 sys follows glob", sys_n, 1'b1);
    rx_edges(4);
    chk("R6 floor hold edge 4", rx_n_h1, 1'b0);
    rx_edges(1);
    chk("R6 floor hold edge 5", rx_n_h1, 1'b1);
    rx_edges(4);
    chk("R3 edge 9", rx_n, 1'b0);
    rx_edges(1);
    chk("R3 edge 10", rx_n, 1'b1);
    sys_edges(3);
    chk("R7 no latch in reset", err, 1'b0);

    // R4 / R6 table: ready dip then count edges from the rise
    for (int i = 0; i < 6; i++) begin
      rdy = 1'b0;
      #0.5;
      chk("R2 ready low", rx_n, 1'b0);
      rx_edges(2);
      rdy = 1'b1;
      rx_edges(int'(VEC[i][0]));
      chk("R4 hold after ready", rx_n, VEC[i][1] != 0);
      chk("R6 floor after ready", rx_n_h1, VEC[i][2] != 0);
    end
    rx_edges(2);

    // R5: one-edge dip restarts the count
    rdy = 1'b0;
    rx_edges(1);
    rdy = 1'b1;
    rx_edges(1);
    chk("R5 restart edge 1", rx_n, 1'b0);
    rx_edges(6);
    chk("R5 restart edge 7", rx_n, 1'b0);
    rx_edges(1);
    chk("R5 restart edge 8", rx_n, 1'b1);

    // R9: stopped clock freezes the count
    rdy = 1'b0;
    rx_edges(2);
    rdy = 1'b1;
    rx_edges(2);
    rx_en = 1'b0;
    #200;
    chk("R9 clock stopped", rx_n, 1'b0);
    rx_en = 1'b1;
    rx_edges(5);
    chk("R9 edge 7 total", rx_n, 1'b0);
    rx_edges(1);
    chk("R9 edge 8 total", rx_n, 1'b1);

    // R7: single flags do not latch
    empty = 1'b1;
    rx_edges(3);
    empty = 1'b0; afull = 1'b1;
    rx_edges(3);
    afull = 1'b0;
    sys_edges(3);
    chk("R7 single flags", err, 1'b0);

    // R8: both flags for one edge, then crossing latency and stickiness
    empty = 1'b1; afull = 1'b1;
    rx_edges(1);
    empty = 1'b0; afull = 1'b0;
    sys_edges(1);
    chk("R8 sys edge 1", err, 1'b0);
    sys_edges(1);
    chk("R8 sys edge 2", err, 1'b1);
    sys_edges(5);
    chk("R8 sticky", err, 1'b1);

    // global reset clears everything at once
    glob_n = 1'b0;
    #0.5;
    chk("R8 cleared by glob", err, 1'b0);
    chk("R2 glob low rx", rx_n, 1'b0);
    chk("R1 glob low sys", sys_n, 1'b0);
    rx_edges(3);
    glob_n = 1'b1;
    #0.2;
    rx_edges(9);
    chk("R3 again edge 9", rx_n, 1'b0);
    rx_edges(1);
    chk("R3 again edge 10", rx_n, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule